// File: doc/BRIEF.md
# Lane Metaframe CRC and Diagnostic Word Checker

This block sits on the receive side of one lane of a framed, multi-lane serial link. It runs after the descrambler. Each cycle it may take one 64-bit word, together with a flag that marks a control word, a marker for the first word of a metaframe, and the lane's block-lock indication. A metaframe holds a fixed number of words, and a diagnostic control word closes it. The checker keeps a CRC-32C over the whole metaframe, which includes the closing diagnostic word with its CRC field taken as zero. It compares the inverted result against the CRC that the diagnostic word carries, and pulses an error when the two differ. Because each lane has its own checker, a CRC failure points to a single lane.

The block also checks the closing word itself. If that word is not a well-formed diagnostic word, a diagnostic error is flagged. If it is well formed, its 2-bit lane status message is captured. While block lock is lost, the diagnostic error is forced high and stays frozen until a new metaframe completes after lock returns. Words that arrive while lock is low, and any metaframe that lock loss cut short, produce no CRC verdict.

Top module: `ildiag_lane_chk`

## Requirements
- R1: After synchronous reset, `crc_err_o`, `lane_status_o` and `diag_err_o` are all zero.
- R2: A valid word with `mf_start_i=1` while `lock_i=1` is word 0 of a metaframe. The following valid locked words are numbered in order, and word `MF_LEN-1` is the final word.
- R3: The CRC is CRC-32C (polynomial 0x1EDC6F41), non-reflected, with each word fed most significant bit first (bit 63 first). The register is preset to all ones at word 0, and every word is fed up to and including the final word, whose bits [31:0] are replaced by zero. The inverted result is compared with bits [31:0] of the final word.
- R4: `crc_err_o` is high for exactly the one cycle after a final word that is a diagnostic word whose carried CRC differs from the computed value. In every other cycle it is low.
- R5: A final word is a diagnostic word when `ctrl_i=1` and bits [63:58] equal 6'b011001. In the cycle after such a word, `lane_status_o` takes bits [33:32] of that word. Otherwise `lane_status_o` holds its value.
- R6: In the cycle after a final word, `diag_err_o` is 1 if that word is not a diagnostic word and 0 if it is one.
- R7: While `lock_i=0`, `diag_err_o` is 1 from the next cycle onward. After lock returns it keeps its value until the next final word updates it.
- R8: Words taken while `lock_i=0` are ignored. Lock loss abandons the open metaframe, so its remaining words change no output, and counting resumes only at the next `mf_start_i`.
- R9: Cycles with `word_valid_i=0` neither advance the word count nor enter the CRC.
- R10: A `mf_start_i` word that arrives inside an open metaframe abandons that metaframe and starts a new one at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_valid_i | input | 1 | A word is present this cycle |
| word_i | input | 64 | Descrambled lane word |
| ctrl_i | input | 1 | Word is a control word |
| mf_start_i | input | 1 | Word is the first of a metaframe |
| lock_i | input | 1 | Lane block lock |
| crc_err_o | output | 1 | One-cycle pulse: metaframe CRC mismatch |
| lane_status_o | output | 2 | Last captured lane status message |
| diag_err_o | output | 1 | Diagnostic word error, held during lock loss |

## Verification
The embedded assertions check the following on every cycle:
- The word counter stays in range.
- Lock loss clears the framing state and raises the diagnostic error on the next cycle.
- The lane status never changes without a diagnostic final word.
- The CRC error is a lone pulse that directly follows a final word.

Only the bench scenarios can show that the CRC value itself is right. The bench does this by sweeping a single flipped bit over every position of a metaframe, and by running clean metaframes with gaps, restarts and lock drops. Those scenarios also show that an abandoned metaframe leaves the outputs unchanged.

// File: rtl/ildiag_pkg.sv
// Package: shared constants and the 64-bit CRC-32C update step.
// Assumes non-reflected CRC, word fed from bit 63 down to bit 0.
package ildiag_pkg;
    localparam logic [31:0] CRC_POLY   = 32'h1EDC6F41;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
    localparam logic [5:0]  DIAG_TYPE  = 6'b011001;

    // Advance a CRC register by one 64-bit word, most significant bit first.
    function automatic logic [31:0] crc_step64(input logic [31:0] c_in,
                                               input logic [63:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 63; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/ildiag_track.sv
// Metaframe position tracker.
// Opens a metaframe on a locked start word and counts valid locked words.
// Flags the first and final positions. Lock loss abandons the metaframe.
// Assumes MF_LEN >= 2, so a start word is never also a final word.
module ildiag_track #(
    parameter int MF_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic start_i,
    input  logic lock_i,
    output logic take_o,
    output logic first_o,
    output logic last_o
);
    localparam int CW = (MF_LEN > 2) ? $clog2(MF_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(MF_LEN - 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          live;

    // Decode this cycle's word position from the stored framing state.
    always_comb begin
        live    = lock_i && valid_i;
        first_o = live && start_i;
        last_o  = live && !start_i && active_q && (cnt_q == LAST_IDX);
        take_o  = first_o || (live && active_q);
    end

    // Keep the framing state: open, count, close, abandon.
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (valid_i) begin
            if (start_i) begin
                active_q <= 1'b1;
                cnt_q    <= CW'(1);
            end else if (active_q) begin
                if (cnt_q == LAST_IDX) begin
                    active_q <= 1'b0;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    initial assert (MF_LEN >= 2) else $error("MF_LEN must be at least 2");

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);
    assert_lockloss_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> (!active_q && cnt_q == '0));
endmodule

// File: rtl/ildiag_crc.sv
// Per-lane CRC-32C accumulator.
// Preset at the first word, it folds in every taken word and gives the inverted
// result including the current word. Assumes the caller already zeroed the CRC
// field of the final word.
module ildiag_crc
    import ildiag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic        first_i,
    input  logic [63:0] data_i,
    output logic [31:0] crc_final_o
);
    logic [31:0] crc_q;
    logic [31:0] crc_nxt;

    // Next CRC value, restarted from the preset on a first word.
    always_comb begin
        crc_nxt     = crc_step64(first_i ? CRC_PRESET : crc_q, data_i);
        crc_final_o = ~crc_nxt;
    end

    // Hold the running CRC between taken words.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_PRESET;
        else if (take_i) crc_q <= crc_nxt;
    end

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(crc_q));
endmodule

// File: rtl/ildiag_diag.sv
// Diagnostic word decoder and status holder.
// Recognises the closing diagnostic control word, captures its lane status and
// keeps the diagnostic error flag. The flag is forced high during lock loss.
module ildiag_diag
    import ildiag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_i,
    input  logic        last_i,
    input  logic        ctrl_i,
    input  logic [63:0] word_i,
    output logic        is_diag_o,
    output logic [1:0]  status_o,
    output logic        diag_err_o
);
    // Classify the word by its control flag and block type field.
    always_comb is_diag_o = ctrl_i && (word_i[63:58] == DIAG_TYPE);

    // Capture the lane status from each diagnostic final word.
    always_ff @(posedge clk) begin
        if (!rst_n)                      status_o <= 2'b00;
        else if (last_i && is_diag_o)    status_o <= word_i[33:32];
    end

    // Keep the diagnostic error: held during lock loss, judged at each final word.
    always_ff @(posedge clk) begin
        if (!rst_n)       diag_err_o <= 1'b0;
        else if (!lock_i) diag_err_o <= 1'b1;
        else if (last_i)  diag_err_o <= !is_diag_o;
    end

    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(last_i && is_diag_o) |=> $stable(status_o));
    assert_lockloss_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> diag_err_o);
endmodule

// File: rtl/ildiag_lane_chk.sv
// Top: per-lane metaframe CRC and diagnostic word checker.
// Assumes descrambled, block-aligned words, and a metaframe length of MF_LEN
// words that ends with a diagnostic control word.
module ildiag_lane_chk #(
    parameter int MF_LEN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_valid_i,
    input  logic [63:0] word_i,
    input  logic        ctrl_i,
    input  logic        mf_start_i,
    input  logic        lock_i,
    output logic        crc_err_o,
    output logic [1:0]  lane_status_o,
    output logic        diag_err_o
);
    logic        take_w, first_w, last_w, is_diag_w;
    logic [63:0] crc_in_w;
    logic [31:0] crc_final_w;
    logic        crc_err_q;

    ildiag_track #(.MF_LEN(MF_LEN)) track_i (
        .clk(clk), .rst_n(rst_n), .valid_i(word_valid_i), .start_i(mf_start_i),
        .lock_i(lock_i), .take_o(take_w), .first_o(first_w), .last_o(last_w)
    );

    // Zero the carried CRC field of the final word before it enters the CRC.
    always_comb crc_in_w = last_w ? {word_i[63:32], 32'h0} : word_i;

    ildiag_crc crc_i (
        .clk(clk), .rst_n(rst_n), .take_i(take_w), .first_i(first_w),
        .data_i(crc_in_w), .crc_final_o(crc_final_w)
    );

    ildiag_diag diag_i (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .last_i(last_w),
        .ctrl_i(ctrl_i), .word_i(word_i), .is_diag_o(is_diag_w),
        .status_o(lane_status_o), .diag_err_o(diag_err_o)
    );

    // Register the one-cycle CRC verdict for a completed diagnostic metaframe.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_err_q <= 1'b0;
        else        crc_err_q <= last_w && is_diag_w && (crc_final_w != word_i[31:0]);
    end

    assign crc_err_o = crc_err_q;

    assert_crc_err_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !last_w |=> !crc_err_o);
    assert_crc_err_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_o |=> !crc_err_o);
endmodule

// File: tb/ildiag_lane_chk_tb.sv
module ildiag_lane_chk_tb_top;
    localparam int L = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0, ctrl = 1'b0, st = 1'b0, lock = 1'b0;
    logic [63:0] wd = '0;
    logic        crc_err, diag_err;
    logic [1:0]  status;

    int n_chk = 0, n_bad = 0;
    logic [63:0] seed = 64'h0123_4567_89AB_CDEF;
    logic [63:0] fr [L];
    logic        fc [L];

    always #2 clk = ~clk;

    ildiag_lane_chk #(.MF_LEN(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .word_valid_i(vld), .word_i(wd), .ctrl_i(ctrl),
        .mf_start_i(st), .lock_i(lock), .crc_err_o(crc_err),
        .lane_status_o(status), .diag_err_o(diag_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    // Bench reference: CRC over a flat bit stream, bit index by bit index.
    function automatic logic [31:0] ref_crc();
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = 0; k < 64 * L; k++) begin
            int wi = k / 64;
            int bi = 63 - (k % 64);
            logic b = (wi == L - 1 && bi < 32) ? 1'b0 : fr[wi][bi];
            logic t = r[31] ^ b;
            r = r << 1;
            if (t) r = r ^ 32'h1EDC6F41;
        end
        return ~r;
    endfunction

    task automatic build(logic [1:0] stat);
        for (int i = 0; i < L - 1; i++) begin
            fr[i] = rnd();
            fc[i] = 1'b0;
        end
        fr[L-1] = {6'b011001, rnd()[57:34], stat, 32'h0};
        fc[L-1] = 1'b1;
        fr[L-1][31:0] = ref_crc();
    endtask

    task automatic drive(logic v, logic [63:0] d, logic c, logic s, logic lk);
        @(negedge clk);
        vld = v; wd = d; ctrl = c; st = s; lock = lk;
        @(posedge clk);
        #1;
    endtask

    // Send the prepared frame, optionally with idle gaps, and check the verdict.
    task automatic send(bit gaps, logic [1:0] prev_stat);
        logic exp_diag = fc[L-1] && (fr[L-1][63:58] == 6'b011001);
        logic exp_err  = exp_diag && (ref_crc() != fr[L-1][31:0]);
        for (int i = 0; i < L; i++) begin
            if (gaps) begin
                drive(1'b0, rnd(), 1'b1, 1'b1, 1'b1);
                check("R9 idle", {31'b0, crc_err}, 32'd0);
            end
            drive(1'b1, fr[i], fc[i], i == 0, 1'b1);
            if (i < L - 1) check("R4 mid", {31'b0, crc_err}, 32'd0);
        end
        check("R4 R3 crc_err", {31'b0, crc_err}, {31'b0, exp_err});
        check("R6 diag_err", {31'b0, diag_err}, {31'b0, !exp_diag});
        check("R5 status", {30'b0, status},
              {30'b0, exp_diag ? fr[L-1][33:32] : prev_stat});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [1:0] last_stat;
        repeat (3) @(posedge clk);
        #1;
        check("R1 crc_err", {31'b0, crc_err}, 32'd0);
        check("R1 status", {30'b0, status}, 32'd0);
        check("R1 diag_err", {31'b0, diag_err}, 32'd0);
        rst_n = 1'b1;
        last_stat = 2'b00;

        // R2 R3 R5 R9: clean metaframes, every status value, with and without gaps.
        for (int k = 0; k < 16; k++) begin
            build(2'(k));
            send(k[2], last_stat);
            last_stat = 2'(k);
        end

        // R3 R4 R6: one flipped bit at every position of the metaframe.
        for (int w = 0; w < L; w++) begin
            for (int b = 0; b < 64; b++) begin
                build(2'(b));
                fr[w][b] = ~fr[w][b];
                send(1'b0, last_stat);
                if (fr[L-1][63:58] == 6'b011001) last_stat = fr[L-1][33:32];
            end
        end

        // R6: final word with the control flag clear.
        build(2'b10);
        fc[L-1] = 1'b0;
        send(1'b0, last_stat);
        build(2'b01);
        send(1'b0, last_stat);
        last_stat = 2'b01;

        // R7 R8: lock lost mid-metaframe; the rest of it must change nothing.
        build(2'b11);
        drive(1'b1, fr[0], 1'b0, 1'b1, 1'b1);
        drive(1'b1, fr[1], 1'b0, 1'b0, 1'b0);
        check("R7 err on lock loss", {31'b0, diag_err}, 32'd1);
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, fr[L-1], 1'b1, 1'b0, 1'b0);
            check("R7 held", {31'b0, diag_err}, 32'd1);
            check("R8 no crc verdict", {31'b0, crc_err}, 32'd0);
        end
        for (int i = 2; i < L; i++) drive(1'b1, fr[i], fc[i], 1'b0, 1'b1);
        check("R8 partial crc", {31'b0, crc_err}, 32'd0);
        check("R8 partial status", {30'b0, status}, {30'b0, last_stat});
        check("R7 frozen after relock", {31'b0, diag_err}, 32'd1);
        build(2'b11);
        send(1'b0, last_stat);
        last_stat = 2'b11;

        // R10: a start word inside an open metaframe restarts the count and the CRC.
        drive(1'b1, rnd(), 1'b0, 1'b1, 1'b1);
        drive(1'b1, rnd(), 1'b0, 1'b0, 1'b1);
        build(2'b00);
        send(1'b0, last_stat);
        check("R10 restart clean", {31'b0, crc_err}, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule